// File: doc/BRIEF.md
# Fixed-Point Hidden Neuron Layer

This block evaluates the hidden layer of a small, already trained feed-forward network using signed fixed-point arithmetic. Four 9-bit input words arrive in parallel and a 2-bit select picks one of them. The chosen word is multiplied by every entry of a weight set fixed at elaboration. Each multiply uses a radix-4 Booth-recoded signed multiplier. The products are reduced by a balanced adder tree into one 18-bit sum.

That single shared sum is then added to each of fifteen bias constants. The results land in fifteen 18-bit registers on the clock edge that samples an input-valid strobe. No activation function is applied: a downstream stage consumes the raw sums. Weights and biases are parameters. Run-time loading is not supported.

An output-valid flag follows the input strobe by one cycle. Between strobes the registered results hold their value.

Top module: `hidden_layer`

## Requirements
- R1: A synchronous active-high reset clears all fifteen outputs to zero and drops `outValid`. Reset takes priority over a simultaneous `inValid`.
- R2: `outValid` is high in exactly the cycle after each clock edge that samples `inValid` high, and low after an edge that samples it low.
- R3: `inSel` = k selects input word k, taken from bits [9k+8:9k] of `inWords`. The words not selected have no effect on the result.
- R4: Hidden output n equals x·(w0+w1+…+wN-1) + bias_n. Here x is the selected word read as 9-bit two's complement, and every weight and bias is also 9-bit two's complement. Products are exact for all operands, including -256.
- R5: All sums wrap modulo 2^18 with no saturation. For example, a true value of +131328 appears as -130816 (18'h20100).
- R6: While `inValid` is low, changes on `inSel` and `inWords` leave every output unchanged.
- R7: Each bias is sign-extended to 18 bits before the addition. Hidden output n occupies bits [18n+17:18n] of `hiddenOut`. With x = 0 each output equals its own bias.
- R8: The outputs change only at a clock edge. A new input that is presented before the edge leaves the previous results visible until that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Strobe: compute and register the layer on this edge |
| inSel | input | 2 | Index of the input word to use |
| inWords | input | 36 | Four packed 9-bit signed input words, word k at bits [9k+8:9k] |
| outValid | output | 1 | High one cycle after an accepted strobe |
| hiddenOut | output | 270 | Fifteen packed 18-bit signed hidden sums, output n at bits [18n+17:18n] |

## Verification
The bench drives the selected word to the extremes +255, -1, and -256. A Booth recoder that mishandles the top digit group, or that treats the multiplier as unsigned, gives results with the wrong sign or magnitude there. One vector pushes the sum past +2^17-1: a design that saturates, or that reduces with too narrow an adder, misses the wrapped value. A zero input exposes bias values that were zero-extended or packed into the wrong output lane. The bench also changes the inputs while the strobe is low and asserts reset together with the strobe. A design that loads without the strobe, or that gives the strobe priority over reset, shows changed outputs in those cycles.

// File: rtl/hl_pkg.sv
package hl_pkg;
  // Coefficient and input word width (two's complement)
  parameter int COEF_W = 9;
  // Accumulator and result width
  parameter int ACC_W = 2 * COEF_W;

  // Strobes from control to datapath
  typedef struct packed {
    logic clear;
    logic load;
  } hl_ctrl_t;
endpackage

// File: rtl/hl_booth_mul.sv
module hl_booth_mul #(
  parameter int W = 9
) (
  input  logic [W-1:0]   mcand,
  input  logic [W-1:0]   mplier,
  output logic [2*W-1:0] product
);
  localparam int P_W  = 2 * W;
  localparam int YE_W = W + (W % 2);
  localparam int GRP  = YE_W / 2;

  logic [YE_W:0]  yExt;
  logic [P_W-1:0] mcandExt;

  assign yExt     = {{(YE_W - W){mplier[W-1]}}, mplier, 1'b0};
  assign mcandExt = {{(P_W - W){mcand[W-1]}}, mcand};

  always_comb begin
    logic [P_W-1:0] acc;
    logic [P_W-1:0] part;
    logic [2:0]     trip;
    acc = '0;
    for (int g = 0; g < GRP; g++) begin
      trip = yExt[2*g +: 3];
      case (trip)
        3'b001, 3'b010: part = mcandExt;
        3'b011:         part = mcandExt << 1;
        3'b100:         part = -(mcandExt << 1);
        3'b101, 3'b110: part = -mcandExt;
        default:        part = '0;
      endcase
      acc = acc + (part << (2 * g));
    end
    product = acc;
  end
endmodule

// File: rtl/hl_control.sv
module hl_control
  import hl_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  output hl_ctrl_t ctrl,
  output logic     outValid
);
  always_comb begin
    ctrl.clear = rst;
    ctrl.load  = inValid && !rst;
  end

  always_ff @(posedge clk) begin
    if (rst) outValid <= 1'b0;
    else     outValid <= inValid;
  end
endmodule

// File: rtl/hl_datapath.sv
module hl_datapath
  import hl_pkg::*;
#(
  parameter int NUM_SEL     = 4,
  parameter int NUM_WEIGHTS = 4,
  parameter int NUM_NEURONS = 15,
  parameter logic [NUM_WEIGHTS*COEF_W-1:0] WEIGHTS = {NUM_WEIGHTS{9'h001}},
  parameter logic [NUM_NEURONS*COEF_W-1:0] BIASES  = {NUM_NEURONS{9'h000}},
  localparam int SEL_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                         clk,
  input  hl_ctrl_t                     ctrl,
  input  logic [SEL_W-1:0]             inSel,
  input  logic [NUM_SEL*COEF_W-1:0]    inWords,
  output logic [NUM_NEURONS*ACC_W-1:0] hiddenOut
);
  localparam int TREE_LV = (NUM_WEIGHTS > 1) ? $clog2(NUM_WEIGHTS) : 0;
  localparam int POW     = 1 << TREE_LV;

  logic [COEF_W-1:0] selWord;
  logic [ACC_W-1:0]  prod [NUM_WEIGHTS];
  logic [ACC_W-1:0]  treeSum;

  // Input word selection
  always_comb begin
    selWord = '0;
    for (int k = 0; k < NUM_SEL; k++) begin
      if (inSel == SEL_W'(k)) selWord = inWords[k*COEF_W +: COEF_W];
    end
  end

  // One Booth multiplier per weight
  for (genvar i = 0; i < NUM_WEIGHTS; i++) begin : g_mul
    hl_booth_mul #(.W(COEF_W)) u_mul (
      .mcand  (WEIGHTS[i*COEF_W +: COEF_W]),
      .mplier (selWord),
      .product(prod[i])
    );
  end

  // Balanced pairwise reduction, padded to a power of two
  always_comb begin
    logic [ACC_W-1:0] lvl [POW];
    for (int i = 0; i < POW; i++) begin
      lvl[i] = (i < NUM_WEIGHTS) ? prod[i] : '0;
    end
    for (int span = POW / 2; span >= 1; span = span / 2) begin
      for (int i = 0; i < span; i++) begin
        lvl[i] = lvl[2*i] + lvl[2*i+1];
      end
    end
    treeSum = lvl[0];
  end

  // Per-neuron bias add and result register
  for (genvar n = 0; n < NUM_NEURONS; n++) begin : g_neuron
    localparam logic [COEF_W-1:0] BIAS = BIASES[n*COEF_W +: COEF_W];
    logic [ACC_W-1:0] biasExt;
    logic [ACC_W-1:0] hidReg;

    assign biasExt = {{(ACC_W - COEF_W){BIAS[COEF_W-1]}}, BIAS};

    always_ff @(posedge clk) begin
      if (ctrl.clear)     hidReg <= '0;
      else if (ctrl.load) hidReg <= treeSum + biasExt;
    end

    assign hiddenOut[n*ACC_W +: ACC_W] = hidReg;
  end
endmodule

// File: rtl/hidden_layer.sv
module hidden_layer
  import hl_pkg::*;
#(
  parameter int NUM_SEL     = 4,
  parameter int NUM_WEIGHTS = 4,
  parameter int NUM_NEURONS = 15,
  parameter logic [NUM_WEIGHTS*COEF_W-1:0] WEIGHTS = {NUM_WEIGHTS{9'h001}},
  parameter logic [NUM_NEURONS*COEF_W-1:0] BIASES  = {NUM_NEURONS{9'h000}},
  localparam int SEL_W = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         inValid,
  input  logic [SEL_W-1:0]             inSel,
  input  logic [NUM_SEL*COEF_W-1:0]    inWords,
  output logic                         outValid,
  output logic [NUM_NEURONS*ACC_W-1:0] hiddenOut
);
  hl_ctrl_t ctrl;

  hl_control u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .ctrl    (ctrl),
    .outValid(outValid)
  );

  hl_datapath #(
    .NUM_SEL    (NUM_SEL),
    .NUM_WEIGHTS(NUM_WEIGHTS),
    .NUM_NEURONS(NUM_NEURONS),
    .WEIGHTS    (WEIGHTS),
    .BIASES     (BIASES)
  ) u_dp (
    .clk      (clk),
    .ctrl     (ctrl),
    .inSel    (inSel),
    .inWords  (inWords),
    .hiddenOut(hiddenOut)
  );
endmodule

// File: rtl/hidden_layer_chk.sv
module hidden_layer_chk
  import hl_pkg::*;
#(
  parameter int NUM_NEURONS = 15,
  parameter logic [NUM_NEURONS*COEF_W-1:0] BIASES = {NUM_NEURONS{9'h000}}
) (
  input logic                         clk,
  input logic                         rst,
  input logic                         inValid,
  input logic                         outValid,
  input logic [NUM_NEURONS*ACC_W-1:0] hiddenOut
);
  localparam logic [COEF_W-1:0] B0 = BIASES[0 +: COEF_W];
  localparam logic [ACC_W-1:0]  B0_EXT = {{(ACC_W - COEF_W){B0[COEF_W-1]}}, B0};

  // R1: reset clears outputs and valid
  p_reset_clear_r1: assert property (@(posedge clk)
    rst |=> (!outValid && hiddenOut == '0));

  // R2: valid follows the strobe by one cycle
  p_valid_rise_r2: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);
  p_valid_fall_r2: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R6: outputs hold without a strobe
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(hiddenOut));

  // R7: lanes differ exactly by their sign-extended bias difference
  for (genvar n = 1; n < NUM_NEURONS; n++) begin : g_lane
    localparam logic [COEF_W-1:0] BN = BIASES[n*COEF_W +: COEF_W];
    localparam logic [ACC_W-1:0]  DIFF =
      {{(ACC_W - COEF_W){BN[COEF_W-1]}}, BN} - B0_EXT;
    p_bias_lane_r7: assert property (@(posedge clk) disable iff (rst)
      outValid |-> (hiddenOut[n*ACC_W +: ACC_W] - hiddenOut[0 +: ACC_W]) == DIFF);
  end
endmodule

bind hidden_layer hidden_layer_chk #(
  .NUM_NEURONS(NUM_NEURONS),
  .BIASES     (BIASES)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .outValid (outValid),
  .hiddenOut(hiddenOut)
);

// File: tb/hidden_layer_tb.sv
module hidden_layer_tb;
  localparam int NN = 15;
  localparam int NV = 8;

  // Weights: w0=-256, w1=+255, w2=-256, w3=-256 (sum -513)
  localparam logic [35:0] TB_W = {9'h100, 9'h100, 9'h0FF, 9'h100};
  localparam int WSUM = -513;

  function automatic int biasInt(input int n);
    return (n == NN - 1) ? 255 : (-256 + 36 * n);
  endfunction

  function automatic logic [NN*9-1:0] mkBias();
    logic [NN*9-1:0] v;
    v = '0;
    for (int n = 0; n < NN; n++) begin
      logic [31:0] b;
      b = 32'(biasInt(n));
      v[n*9 +: 9] = b[8:0];
    end
    return v;
  endfunction

  // Each entry: {sel, word3, word2, word1, word0}
  localparam logic [37:0] VEC [NV] = '{
    {2'd0, 9'h0AA, 9'h133, 9'h07F, 9'h001},
    {2'd1, 9'h011, 9'h022, 9'h1FF, 9'h044},
    {2'd2, 9'h1C0, 9'h0FF, 9'h100, 9'h033},
    {2'd3, 9'h100, 9'h0FF, 9'h001, 9'h1FF},
    {2'd0, 9'h0FF, 9'h100, 9'h0FF, 9'h000},
    {2'd2, 9'h001, 9'h055, 9'h002, 9'h003},
    {2'd3, 9'h13C, 9'h07E, 9'h0C1, 9'h1F0},
    {2'd1, 9'h000, 9'h000, 9'h07F, 9'h000}
  };

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic [1:0]   inSel = '0;
  logic [35:0]  inWords = '0;
  logic         outValid;
  logic [NN*18-1:0] hiddenOut;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  hidden_layer #(
    .NUM_SEL(4), .NUM_WEIGHTS(4), .NUM_NEURONS(NN),
    .WEIGHTS(TB_W), .BIASES(mkBias())
  ) u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .inSel(inSel),
    .inWords(inWords), .outValid(outValid), .hiddenOut(hiddenOut)
  );

  function automatic int selX(input logic [37:0] e);
    logic signed [8:0] xs;
    logic [1:0] s;
    s  = e[37:36];
    xs = e[9*s +: 9];
    return int'(xs);
  endfunction

  task automatic checkBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s outValid actual %0b expected %0b", req, act, exp);
    end
  endtask

  // zeroExp=1: all outputs must be zero
  task automatic checkOuts(input string req, input int x, input bit zeroExp);
    for (int n = 0; n < NN; n++) begin
      logic [31:0] full;
      logic [17:0] exp;
      full = zeroExp ? 32'd0 : 32'(x * WSUM + biasInt(n));
      exp  = full[17:0];
      checks++;
      if (hiddenOut[n*18 +: 18] !== exp) begin
        errors++;
        $display("FAIL %s lane %0d actual %h expected %h", req, n,
                 hiddenOut[n*18 +: 18], exp);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int lastX;
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkBit("R1", outValid, 1'b0);
    checkOuts("R1", 0, 1'b1);
    rst = 1'b0;

    // Table walk with back-to-back strobes
    lastX = 0;
    for (int v = 0; v < NV; v++) begin
      string tag;
      tag = (v == 3) ? "R5" : (v == 4) ? "R7" : "R3 R4";
      inSel   = VEC[v][37:36];
      inWords = VEC[v][35:0];
      inValid = 1'b1;
      if (v > 0) begin
        #1;
        checkOuts("R8", lastX, 1'b0);
      end
      @(negedge clk);
      checkBit("R2", outValid, 1'b1);
      checkOuts(tag, selX(VEC[v]), 1'b0);
      lastX = selX(VEC[v]);
    end

    // Strobe low: input changes are ignored
    inValid = 1'b0;
    inSel   = 2'd2;
    inWords = {9'h155, 9'h0AB, 9'h1FE, 9'h003};
    @(negedge clk);
    checkBit("R2", outValid, 1'b0);
    checkOuts("R6", lastX, 1'b0);
    inSel = 2'd0;
    @(negedge clk);
    checkOuts("R6", lastX, 1'b0);

    // Single strobe pulse
    inSel   = 2'd3;
    inWords = {9'h0FF, 9'h000, 9'h000, 9'h000};
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkBit("R2", outValid, 1'b1);
    checkOuts("R4", 255, 1'b0);
    @(negedge clk);
    checkBit("R2", outValid, 1'b0);

    // Reset together with a strobe
    inValid = 1'b1;
    rst     = 1'b1;
    @(negedge clk);
    checkBit("R1", outValid, 1'b0);
    checkOuts("R1", 0, 1'b1);
    rst     = 1'b0;
    inValid = 1'b0;
    @(negedge clk);
    checkOuts("R1", 0, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule